// File: doc/BRIEF.md
# Peripheral Region Attribute Override

This block holds a programmable address window and rewrites the memory attributes of every access that lands inside it. Any address inside the window is treated as a non-shared device access and is steered to the peripheral port. The attributes that arrive from translation or from the other remap stages do not matter for such an access. Addresses outside the window keep their incoming attributes unchanged. The override works in the same way whether address translation is on or off, because the block only looks at the address and at the attributes it is given.

The window is described by one 32-bit configuration word. Bits 31:12 hold the base address, bits 4:0 hold a size code, and bits 11:5 are reserved. The block keeps two copies of this word, one for the secure world and one for the non-secure world. The `world_ns` input selects which copy is read, written and used for matching. Only privileged software may access the word. An unprivileged attempt raises a fault flag in the same cycle and changes nothing. A privileged write takes effect at the next rising clock edge. The read data and the attribute path are combinational.

The attribute path has no registers. Its data path is: select the bank → decode the size code into a low-bit mask → compare the masked address with the masked base → choose between the override attributes and the incoming attributes.

Top module: `ppr_override_top`

## Requirements
- R1: A write with `cfg_wr`=1 and `cfg_priv`=1 stores the base field (bits 31:12) and the size field (bits 4:0) into the bank selected by `world_ns` (0 = secure, 1 = non-secure) at the next rising edge. A privileged read then returns the stored value on `cfg_rdata`.
- R2: Write data in bits 11:5 is discarded, and those bits always read as zero.
- R3: The two banks are independent. A write to one world's bank leaves the other bank unchanged. Matching uses only the bank of the current `world_ns`.
- R4: When `cfg_wr` or `cfg_rd` is high while `cfg_priv`=0, `cfg_fault` is 1 in that cycle. No bank changes, and `cfg_rdata` is zero. In every other case `cfg_fault` is 0.
- R5: After reset, both banks hold zero, both read as zero, and `per_sel` is 0 for every address.
- R6: Size codes 1 to 20 define a window of 2^(code+11) bytes (4 KB up to 2 GB). The base is aligned down to the window size, so address bits below the window size are not compared.
- R7: Size code 0, and every size code above 20, disables the window.
- R8: On a hit, `per_sel`=1, `out_memtype`=2'b01 (device) and `out_shared`=0, whatever the incoming attributes are. The memtype encoding is 2'b00 strongly ordered, 2'b01 device and 2'b10 normal.
- R9: On a miss, `per_sel`=0, and `out_memtype` and `out_shared` equal `in_memtype` and `in_shared`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_priv | input | 1 | 1 when the requester is privileged |
| world_ns | input | 1 | Security world: 0 secure, 1 non-secure |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected bank, or zero when unprivileged |
| cfg_fault | output | 1 | Unprivileged access attempt |
| acc_addr | input | 32 | Access address |
| in_memtype | input | 2 | Incoming memory type |
| in_shared | input | 1 | Incoming shareable flag |
| out_memtype | output | 2 | Final memory type |
| out_shared | output | 1 | Final shareable flag |
| per_sel | output | 1 | Access is steered to the peripheral port |

## Verification
The assertions read the selected bank through `cfg_rdata`, so the window checks only hold in cycles where `cfg_priv` is high and no write is in flight. The unprivileged-write check also assumes a privileged, write-free cycle on the same world on either side of the attempt. The bench follows this discipline: it holds `cfg_priv`=1 and `cfg_wr`=0 while it probes addresses, and it wraps each unprivileged write in privileged idle cycles. Between edges it changes `world_ns` only when no write is pending.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;
    localparam int PPR_ADDR_W   = 32;
    localparam int PPR_BASE_LSB = 12;
    localparam int PPR_SIZE_W   = 5;
    localparam int PPR_MAX_CODE = 20;

    typedef enum logic [1:0] {
        MT_STRONG = 2'b00,
        MT_DEVICE = 2'b01,
        MT_NORMAL = 2'b10,
        MT_RSVD   = 2'b11
    } memtype_e;
endpackage

// File: rtl/ppr_bank_regs.sv
`timescale 1ns/1ps
module ppr_bank_regs #(
    parameter int ADDR_W   = ppr_pkg::PPR_ADDR_W,
    parameter int BASE_LSB = ppr_pkg::PPR_BASE_LSB,
    parameter int SIZE_W   = ppr_pkg::PPR_SIZE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic                   cfg_rd,
    input  logic                   cfg_priv,
    input  logic                   world_ns,
    input  logic [ADDR_W-1:0]      cfg_wdata,
    output logic [ADDR_W-1:0]      cfg_rdata,
    output logic                   cfg_fault,
    output logic [ADDR_W-BASE_LSB-1:0] sel_base,
    output logic [SIZE_W-1:0]      sel_size
);
    localparam logic [ADDR_W-1:0] LOW_ONES  = ADDR_W'((64'd1 << BASE_LSB) - 64'd1);
    localparam logic [ADDR_W-1:0] SIZE_ONES = ADDR_W'((64'd1 << SIZE_W) - 64'd1);
    localparam logic [ADDR_W-1:0] KEEP_MASK = ~(LOW_ONES & ~SIZE_ONES);

    logic [ADDR_W-1:0] bank_q [2];
    logic [ADDR_W-1:0] sel_word;

    // one storage word per security world
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else if (cfg_wr && cfg_priv && (world_ns == 1'(b))) begin
                bank_q[b] <= cfg_wdata & KEEP_MASK;
            end
        end
    end

    always_comb begin
        sel_word  = bank_q[world_ns];
        sel_base  = sel_word[ADDR_W-1:BASE_LSB];
        sel_size  = sel_word[SIZE_W-1:0];
        cfg_rdata = cfg_priv ? sel_word : '0;
        cfg_fault = (cfg_wr || cfg_rd) && !cfg_priv;
    end
endmodule

// File: rtl/ppr_size_decode.sv
`timescale 1ns/1ps
module ppr_size_decode #(
    parameter int ADDR_W   = ppr_pkg::PPR_ADDR_W,
    parameter int BASE_LSB = ppr_pkg::PPR_BASE_LSB,
    parameter int SIZE_W   = ppr_pkg::PPR_SIZE_W,
    parameter int MAX_CODE = ppr_pkg::PPR_MAX_CODE
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic              region_en,
    output logic [ADDR_W-1:0] low_mask
);
    assign region_en = (size_code != '0) && (size_code <= SIZE_W'(MAX_CODE));

    // bit i is ignored in the compare when it lies below the window size
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign low_mask[i] = region_en && (i < (int'(size_code) + BASE_LSB - 1));
    end
endmodule

// File: rtl/ppr_attr_override.sv
`timescale 1ns/1ps
module ppr_attr_override #(
    parameter int ADDR_W   = ppr_pkg::PPR_ADDR_W,
    parameter int BASE_LSB = ppr_pkg::PPR_BASE_LSB
) (
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [ADDR_W-BASE_LSB-1:0] base_field,
    input  logic                       region_en,
    input  logic [ADDR_W-1:0]          low_mask,
    input  logic [1:0]                 in_memtype,
    input  logic                       in_shared,
    output logic [1:0]                 out_memtype,
    output logic                       out_shared,
    output logic                       per_sel
);
    import ppr_pkg::*;

    logic [ADDR_W-1:0] base_addr;
    logic              hit;

    always_comb begin
        base_addr = {base_field, {BASE_LSB{1'b0}}};
        hit       = region_en && (((acc_addr ^ base_addr) & ~low_mask) == '0);
        per_sel   = hit;
        if (hit) begin
            out_memtype = MT_DEVICE;
            out_shared  = 1'b0;
        end else begin
            out_memtype = in_memtype;
            out_shared  = in_shared;
        end
    end
endmodule

// File: rtl/ppr_override_top.sv
`timescale 1ns/1ps
module ppr_override_top #(
    parameter int ADDR_W   = ppr_pkg::PPR_ADDR_W,
    parameter int BASE_LSB = ppr_pkg::PPR_BASE_LSB,
    parameter int SIZE_W   = ppr_pkg::PPR_SIZE_W,
    parameter int MAX_CODE = ppr_pkg::PPR_MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic              cfg_priv,
    input  logic              world_ns,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              cfg_fault,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        in_memtype,
    input  logic              in_shared,
    output logic [1:0]        out_memtype,
    output logic              out_shared,
    output logic              per_sel
);
    localparam int BASE_W = ADDR_W - BASE_LSB;

    logic [BASE_W-1:0] sel_base;
    logic [SIZE_W-1:0] sel_size;
    logic              region_en;
    logic [ADDR_W-1:0] low_mask;

    ppr_bank_regs #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_priv(cfg_priv), .world_ns(world_ns), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_fault(cfg_fault),
        .sel_base(sel_base), .sel_size(sel_size)
    );

    ppr_size_decode #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W),
                      .MAX_CODE(MAX_CODE)) u_dec (
        .size_code(sel_size), .region_en(region_en), .low_mask(low_mask)
    );

    ppr_attr_override #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_ovr (
        .acc_addr(acc_addr), .base_field(sel_base), .region_en(region_en),
        .low_mask(low_mask), .in_memtype(in_memtype), .in_shared(in_shared),
        .out_memtype(out_memtype), .out_shared(out_shared), .per_sel(per_sel)
    );
endmodule

// File: rtl/ppr_override_chk.sv
`timescale 1ns/1ps
module ppr_override_chk #(
    parameter int ADDR_W   = ppr_pkg::PPR_ADDR_W,
    parameter int BASE_LSB = ppr_pkg::PPR_BASE_LSB,
    parameter int SIZE_W   = ppr_pkg::PPR_SIZE_W,
    parameter int MAX_CODE = ppr_pkg::PPR_MAX_CODE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic              cfg_priv,
    input logic              world_ns,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              cfg_fault,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        in_memtype,
    input logic              in_shared,
    input logic [1:0]        out_memtype,
    input logic              out_shared,
    input logic              per_sel
);
    logic [SIZE_W-1:0] seen_size;
    assign seen_size = cfg_rdata[SIZE_W-1:0];

    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[BASE_LSB-1:SIZE_W] == '0);

    a_r4_user_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_priv |-> cfg_rdata == '0);

    a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fault |-> ((cfg_wr || cfg_rd) && !cfg_priv));

    // R4: a privileged view before and after an unprivileged write must agree
    a_r4_user_wr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_priv && $past(cfg_priv) && !$past(cfg_wr)
         && ($past(world_ns) == world_ns))
        |=> (!(cfg_priv && !cfg_wr && (world_ns == $past(world_ns)))
             || (cfg_rdata == $past(cfg_rdata, 2))));

    a_r7_disabled_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_priv && ((seen_size == '0) || (seen_size > SIZE_W'(MAX_CODE))))
        |-> !per_sel);

    a_r6_top_bit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_priv && per_sel) |-> (acc_addr[ADDR_W-1] == cfg_rdata[ADDR_W-1]));

    a_r8_hit_device: assert property (@(posedge clk) disable iff (!rst_n)
        per_sel |-> (out_memtype == 2'b01 && !out_shared));

    a_r9_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !per_sel |-> (out_memtype == in_memtype && out_shared == in_shared));
endmodule

bind ppr_override_top ppr_override_chk #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W), .MAX_CODE(MAX_CODE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_priv(cfg_priv), .world_ns(world_ns), .cfg_rdata(cfg_rdata),
    .cfg_fault(cfg_fault), .acc_addr(acc_addr), .in_memtype(in_memtype),
    .in_shared(in_shared), .out_memtype(out_memtype), .out_shared(out_shared),
    .per_sel(per_sel)
);

// File: tb/ppr_override_top_tb_top.sv
`timescale 1ns/1ps
module ppr_override_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_priv = 1'b1, world_ns = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata, acc_addr = '0;
    logic        cfg_fault;
    logic [1:0]  in_memtype = 2'b10, out_memtype;
    logic        in_shared = 1'b1, out_shared, per_sel;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppr_override_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_priv(cfg_priv), .world_ns(world_ns), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_fault(cfg_fault), .acc_addr(acc_addr),
        .in_memtype(in_memtype), .in_shared(in_shared),
        .out_memtype(out_memtype), .out_shared(out_shared), .per_sel(per_sel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // privileged write, applied at the next rising edge
    task automatic wr_cfg(logic ns, logic [31:0] d);
        @(negedge clk);
        world_ns = ns; cfg_priv = 1'b1; cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic ns, logic [31:0] exp);
        world_ns = ns; cfg_priv = 1'b1; cfg_rd = 1'b1;
        #1;
        chk(req, cfg_rdata, exp);
        chk({req, " fault"}, 32'(cfg_fault), 32'd0);
        cfg_rd = 1'b0;
    endtask

    task automatic probe(string req, logic ns, logic [31:0] a, logic [1:0] mt,
                         logic sh, bit hit);
        world_ns = ns; acc_addr = a; in_memtype = mt; in_shared = sh;
        #1;
        chk({req, " sel"}, 32'(per_sel), 32'(hit));
        chk({req, " attr"}, {29'd0, out_memtype, out_shared},
            hit ? {29'd0, 2'b01, 1'b0} : {29'd0, mt, sh});
    endtask

    task automatic t_reset;
        rd_chk("R5 sec reads zero", 1'b0, 32'h0);
        rd_chk("R5 ns reads zero", 1'b1, 32'h0);
        probe("R5 no sel sec", 1'b0, 32'h0000_0000, 2'b10, 1'b1, 1'b0);
        probe("R5 no sel ns", 1'b1, 32'hFFFF_FFFF, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_basic;
        wr_cfg(1'b0, 32'h4000_0FE1);
        rd_chk("R1/R2 readback", 1'b0, 32'h4000_0001);
        probe("R6 4K low edge", 1'b0, 32'h4000_0000, 2'b10, 1'b1, 1'b1);
        probe("R6 4K high edge", 1'b0, 32'h4000_0FFF, 2'b10, 1'b1, 1'b1);
        probe("R9 above window", 1'b0, 32'h4000_1000, 2'b10, 1'b1, 1'b0);
        probe("R9 below window", 1'b0, 32'h3FFF_FFFC, 2'b00, 1'b1, 1'b0);
    endtask

    task automatic t_banks;
        rd_chk("R3 ns untouched", 1'b1, 32'h0);
        probe("R3 ns no match", 1'b1, 32'h4000_0010, 2'b10, 1'b0, 1'b0);
        wr_cfg(1'b1, 32'h1234_5002);
        rd_chk("R3 sec kept", 1'b0, 32'h4000_0001);
        rd_chk("R1 ns readback", 1'b1, 32'h1234_5002);
        probe("R6 aligned base", 1'b1, 32'h1234_4000, 2'b10, 1'b1, 1'b1);
        probe("R6 8K top", 1'b1, 32'h1234_5FFF, 2'b10, 1'b1, 1'b1);
        probe("R6 past 8K", 1'b1, 32'h1234_6000, 2'b10, 1'b1, 1'b0);
        probe("R3 sec uses own bank", 1'b0, 32'h1234_4000, 2'b10, 1'b1, 1'b0);
    endtask

    task automatic t_sizes;
        wr_cfg(1'b0, 32'h8012_3014);
        probe("R6 2G top", 1'b0, 32'hFFFF_FFFF, 2'b10, 1'b1, 1'b1);
        probe("R6 2G base", 1'b0, 32'h8000_0000, 2'b10, 1'b1, 1'b1);
        probe("R6 2G below", 1'b0, 32'h7FFF_FFFF, 2'b10, 1'b1, 1'b0);
        wr_cfg(1'b0, 32'h8000_0013);
        probe("R6 1G inside", 1'b0, 32'hBFFF_FFFF, 2'b10, 1'b1, 1'b1);
        probe("R6 1G outside", 1'b0, 32'hC000_0000, 2'b10, 1'b1, 1'b0);
        wr_cfg(1'b0, 32'h8000_0015);
        probe("R7 code 21 off", 1'b0, 32'h8000_0000, 2'b10, 1'b1, 1'b0);
        wr_cfg(1'b0, 32'h8000_001F);
        probe("R7 code 31 off", 1'b0, 32'h8000_0000, 2'b10, 1'b1, 1'b0);
        wr_cfg(1'b0, 32'h8000_0000);
        probe("R7 code 0 off", 1'b0, 32'h8000_0000, 2'b10, 1'b1, 1'b0);
    endtask

    task automatic t_user;
        wr_cfg(1'b0, 32'h4000_0001);
        @(negedge clk);
        world_ns = 1'b0; cfg_priv = 1'b0; cfg_wr = 1'b1; cfg_wdata = 32'hDEAD_0003;
        #1;
        chk("R4 fault on user write", 32'(cfg_fault), 32'd1);
        chk("R4 user rdata zero", cfg_rdata, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_priv = 1'b1;
        @(negedge clk);
        rd_chk("R4 bank unchanged", 1'b0, 32'h4000_0001);
        probe("R4 window unchanged", 1'b0, 32'hDEAD_0000, 2'b10, 1'b1, 1'b0);
        cfg_priv = 1'b0; cfg_rd = 1'b1;
        #1;
        chk("R4 fault on user read", 32'(cfg_fault), 32'd1);
        chk("R4 user read zero", cfg_rdata, 32'h0);
        cfg_rd = 1'b0; cfg_priv = 1'b1;
        #1;
        chk("R4 no fault when idle", 32'(cfg_fault), 32'd0);
    endtask

    task automatic t_prio;
        probe("R8 over strong", 1'b0, 32'h4000_0800, 2'b00, 1'b1, 1'b1);
        probe("R8 over device shared", 1'b0, 32'h4000_0004, 2'b01, 1'b1, 1'b1);
        probe("R8 over normal", 1'b0, 32'h4000_0FFC, 2'b10, 1'b0, 1'b1);
        probe("R9 pass reserved", 1'b0, 32'h5000_0000, 2'b11, 1'b0, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_banks();
        t_sizes();
        t_user();
        t_prio();
        @(negedge clk);
        finish_run();
    end

    initial begin
        #(4 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule